// File: doc/BRIEF.md
# APM Command Trap with SMI Gate

This block sits behind the APM control port of a power-management unit. Every byte that software writes to that port is latched and decoded. Two reserved command codes act on the ACPI/SCI enable bit: one code sets the bit and the other clears it. Neither of these codes ever produces a system-management interrupt. Every other code becomes a request for a system-management interrupt, but only when a gate bit in a locally held configuration dword allows it.

The SMI request is a sticky level. It stays high until the SMM side pulses an acknowledge for one clock.

The configuration dword covers four configuration bytes. Firmware writes it through a byte-enabled write port and can read it back. Reset is synchronous and clears the whole dword. The one exception applies when the platform strap reports that SMM is absent: reset then loads the gate byte with 0x02, which leaves the SMI path open.

Top module: `apm_smi_trap`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sci_en`, `smi_req` and `port_rdata` become 0. `cfg_rdata` becomes 0x00000000 when `smm_present` is 1. It becomes 0x02000000 when `smm_present` is 0, which is gate byte 3 holding 0x02.
- R2: A port write of 0xF1 sets `sci_en` on the next clock. It never raises `smi_req`, whatever the gate.
- R3: A port write of 0xF0 clears `sci_en` on the next clock. It never raises `smi_req`, whatever the gate.
- R4: A port write of any code other than 0xF0 or 0xF1 sets `smi_req` on the next clock when the gate bit `cfg_rdata[25]` (byte 3, bit 1) is 1. Such a write leaves `sci_en` unchanged.
- R5: A port write of any code other than 0xF0 or 0xF1 leaves `smi_req` unchanged when `cfg_rdata[25]` is 0.
- R6: Once set, `smi_req` stays high until a cycle with `smi_ack` high. Without a new request in that cycle, it is low on the next clock.
- R7: `smi_ack` in the same cycle as an SMI-raising port write leaves `smi_req` high on the next clock.
- R8: `port_rdata` shows, from the next clock on, the last byte written to the port, the two ACPI command codes included.
- R9: A config write updates, on the next clock, exactly the bytes of `cfg_rdata` whose `cfg_be` bit is 1. The other bytes are kept. Bits of byte 3 other than bit 1 are stored but do not gate the SMI path.
- R10: A port write decides the SMI path with the gate value stored before that clock. A config write in the same cycle takes effect only for later port writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_present | input | 1 | Platform strap, 1 when SMM is supported; read during reset |
| port_wr | input | 1 | One-cycle write strobe for the APM control port |
| port_wdata | input | 8 | Byte written to the control port |
| port_rdata | output | 8 | Last byte written to the control port |
| cfg_wr | input | 1 | Config dword write strobe |
| cfg_be | input | 4 | Byte enables for the config write |
| cfg_wdata | input | 32 | Config write data; byte 3 holds the SMI gate in bit 1 |
| cfg_rdata | output | 32 | Stored config dword |
| smi_ack | input | 1 | One-cycle SMI acknowledge |
| sci_en | output | 1 | ACPI/SCI enable bit |
| smi_req | output | 1 | Sticky SMI request level |

## Verification
An SMI-raising port write can land in the same cycle as an acknowledge. A port write can also land in the same cycle as a config write that changes the gate. Directed cases force both collisions. In the first, the request must survive the acknowledge. In the second, the write must be judged by the old gate value.

The randomized phase mixes acknowledges, the two ACPI codes, other codes and gate writes, so these coincidences also recur at random. A bench model judges the result of every cycle. The model applies the acknowledge after the raise and samples the gate before the config update.

// File: rtl/apm_trap_pkg.sv
package apm_trap_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_ACPI_ON  = 2'd1,
    CMD_ACPI_OFF = 2'd2,
    CMD_TRAP     = 2'd3
  } apm_cmd_e;

  function automatic apm_cmd_e classify(input logic wr, input logic [7:0] data,
                                        input logic [7:0] on_code,
                                        input logic [7:0] off_code);
    if (!wr) return CMD_NONE;
    if (data == on_code) return CMD_ACPI_ON;
    if (data == off_code) return CMD_ACPI_OFF;
    return CMD_TRAP;
  endfunction

  function automatic logic [BYTE_W-1:0] byte_reset(input int unsigned idx,
                                                   input int unsigned gate_idx,
                                                   input logic smm,
                                                   input logic [BYTE_W-1:0] nosmm_val);
    return (idx == gate_idx && !smm) ? nosmm_val : '0;
  endfunction

  function automatic logic [BYTE_W-1:0] byte_merge(input logic [BYTE_W-1:0] old_v,
                                                   input logic [BYTE_W-1:0] new_v,
                                                   input logic en);
    return en ? new_v : old_v;
  endfunction

  function automatic logic smi_next(input logic cur, input logic raise, input logic ack);
    return raise | (cur & ~ack);
  endfunction
endpackage

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
  import apm_trap_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_ON = 8'hF1,
  parameter logic [DATA_W-1:0] CMD_OFF = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_wr,
  input  logic [DATA_W-1:0] port_wdata,
  output logic [DATA_W-1:0] port_q,
  output logic              acpi_on_evt,
  output logic              acpi_off_evt,
  output logic              trap_evt
);
  apm_cmd_e cmd;

  always_comb begin
    cmd          = classify(port_wr, port_wdata, CMD_ON, CMD_OFF);
    acpi_on_evt  = (cmd == CMD_ACPI_ON);
    acpi_off_evt = (cmd == CMD_ACPI_OFF);
    trap_evt     = (cmd == CMD_TRAP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) port_q <= '0;
    else if (port_wr) port_q <= port_wdata;
  end
endmodule

// File: rtl/apm_cfg_regs.sv
module apm_cfg_regs
  import apm_trap_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 4,
  parameter int unsigned GATE_BYTE = 3,
  parameter logic [7:0]  NOSMM_BYTE = 8'h02,
  localparam int unsigned CFG_W = CFG_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smm_present,
  input  logic                 cfg_wr,
  input  logic [CFG_BYTES-1:0] cfg_be,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_q
);
  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= byte_reset(b, GATE_BYTE, smm_present, NOSMM_BYTE);
      else
        q <= byte_merge(q, cfg_wdata[b*BYTE_W +: BYTE_W], cfg_wr & cfg_be[b]);
    end
    assign cfg_q[b*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/apm_smi_latch.sv
module apm_smi_latch
  import apm_trap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic ack,
  output logic smi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) smi_q <= 1'b0;
    else smi_q <= smi_next(smi_q, raise, ack);
  end
endmodule

// File: rtl/apm_smi_trap.sv
module apm_smi_trap
  import apm_trap_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CFG_BYTES = 4,
  parameter logic [DATA_W-1:0] CMD_ON = 8'hF1,
  parameter logic [DATA_W-1:0] CMD_OFF = 8'hF0,
  parameter int unsigned GATE_BYTE = 3,
  parameter int unsigned GATE_BIT = 1,
  parameter logic [7:0] NOSMM_BYTE = 8'h02,
  localparam int unsigned CFG_W = CFG_BYTES * BYTE_W,
  localparam int unsigned GATE_IDX = GATE_BYTE * BYTE_W + GATE_BIT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smm_present,
  input  logic                 port_wr,
  input  logic [DATA_W-1:0]    port_wdata,
  output logic [DATA_W-1:0]    port_rdata,
  input  logic                 cfg_wr,
  input  logic [CFG_BYTES-1:0] cfg_be,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic                 smi_ack,
  output logic                 sci_en,
  output logic                 smi_req
);
  logic acpi_on_evt, acpi_off_evt, trap_evt;
  logic smi_gate, smi_raise_evt, acpi_cmd_evt;

  apm_cmd_decode #(.DATA_W(DATA_W), .CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF)) u_dec (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
    .port_q(port_rdata), .acpi_on_evt(acpi_on_evt), .acpi_off_evt(acpi_off_evt),
    .trap_evt(trap_evt)
  );

  apm_cfg_regs #(.CFG_BYTES(CFG_BYTES), .GATE_BYTE(GATE_BYTE), .NOSMM_BYTE(NOSMM_BYTE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .smm_present(smm_present), .cfg_wr(cfg_wr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_q(cfg_rdata)
  );

  // Gate is the stored value, so a same-cycle config write applies later.
  assign smi_gate      = cfg_rdata[GATE_IDX];
  assign smi_raise_evt = trap_evt & smi_gate;
  assign acpi_cmd_evt  = acpi_on_evt | acpi_off_evt;

  apm_smi_latch u_smi (
    .clk(clk), .rst_n(rst_n), .raise(smi_raise_evt), .ack(smi_ack), .smi_q(smi_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sci_en <= 1'b0;
    else if (acpi_on_evt) sci_en <= 1'b1;
    else if (acpi_off_evt) sci_en <= 1'b0;
  end
endmodule

// File: rtl/apm_smi_trap_checker.sv
module apm_smi_trap_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CFG_W = 32,
  parameter logic [DATA_W-1:0] CMD_ON = 8'hF1,
  parameter logic [DATA_W-1:0] CMD_OFF = 8'hF0,
  parameter int unsigned GATE_IDX = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_wr,
  input logic [DATA_W-1:0] port_wdata,
  input logic [DATA_W-1:0] port_rdata,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic              smi_ack,
  input logic              sci_en,
  input logic              smi_req,
  input logic              smi_raise_evt,
  input logic              acpi_cmd_evt
);
  logic other_wr;
  assign other_wr = port_wr && (port_wdata != CMD_ON) && (port_wdata != CMD_OFF);

  assert_acpi_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && port_wdata == CMD_ON) |=> sci_en);
  assert_acpi_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && port_wdata == CMD_OFF) |=> !sci_en);
  assert_acpi_no_smi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acpi_cmd_evt && !smi_req) |=> !smi_req);
  assert_gate_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr && cfg_rdata[GATE_IDX]) |=> smi_req);
  assert_other_keeps_sci_R4: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> $stable(sci_en));
  assert_gate_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr && !cfg_rdata[GATE_IDX] && !smi_req && !smi_ack) |=> !smi_req);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && !smi_ack) |=> smi_req);
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_ack && !smi_raise_evt) |=> !smi_req);
  assert_ack_race_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_ack && smi_raise_evt) |=> smi_req);
  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (port_rdata == $past(port_wdata)));
endmodule

bind apm_smi_trap apm_smi_trap_checker #(
  .DATA_W(DATA_W), .CFG_W(CFG_W), .CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF), .GATE_IDX(GATE_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
  .port_rdata(port_rdata), .cfg_rdata(cfg_rdata), .smi_ack(smi_ack), .sci_en(sci_en),
  .smi_req(smi_req), .smi_raise_evt(smi_raise_evt), .acpi_cmd_evt(acpi_cmd_evt)
);

// File: tb/apm_smi_trap_bench.sv
`timescale 1ns/1ps
module apm_smi_trap_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, smm_present = 1'b1;
  logic port_wr = 1'b0, cfg_wr = 1'b0, smi_ack = 1'b0;
  logic [7:0] port_wdata = '0, port_rdata;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic sci_en, smi_req;

  int checks = 0, errors = 0;
  bit exp_sci, exp_smi;
  logic [7:0] exp_rd;
  logic [31:0] exp_cfg;

  always #2.5 clk = ~clk;

  apm_smi_trap u_apm_smi_trap (
    .clk(clk), .rst_n(rst_n), .smm_present(smm_present), .port_wr(port_wr),
    .port_wdata(port_wdata), .port_rdata(port_rdata), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smi_ack(smi_ack), .sci_en(sci_en),
    .smi_req(smi_req)
  );

  function automatic bit is_acpi_code(input logic [7:0] d);
    return d == 8'hF1 || d == 8'hF0;
  endfunction

  function automatic logic [31:0] merge_cfg(input logic [31:0] old_v, input logic [31:0] new_v,
                                            input logic [3:0] be);
    logic [31:0] r = old_v;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "sci_en", {31'd0, sci_en}, {31'd0, exp_sci});
    check(tag, "smi_req", {31'd0, smi_req}, {31'd0, exp_smi});
    check(tag, "port_rdata", {24'd0, port_rdata}, {24'd0, exp_rd});
    check(tag, "cfg_rdata", cfg_rdata, exp_cfg);
  endtask

  task automatic do_reset(input bit smm, input string tag);
    @(negedge clk);
    rst_n = 1'b0; smm_present = smm;
    port_wr = 0; cfg_wr = 0; smi_ack = 0;
    @(posedge clk); @(posedge clk); #1;
    exp_sci = 0; exp_smi = 0; exp_rd = 0;
    exp_cfg = smm ? 32'h0 : 32'h0200_0000;
    check_all(tag);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cyc(input bit pw, input logic [7:0] pd, input bit cw, input logic [3:0] be,
                     input logic [31:0] cd, input bit ack, input string tag);
    bit raise;
    @(negedge clk);
    port_wr = pw; port_wdata = pd; cfg_wr = cw; cfg_be = be; cfg_wdata = cd; smi_ack = ack;
    @(posedge clk);
    raise = pw && !is_acpi_code(pd) && exp_cfg[25];
    if (pw) begin
      exp_rd = pd;
      if (pd == 8'hF1) exp_sci = 1;
      else if (pd == 8'hF0) exp_sci = 0;
    end
    exp_smi = raise | (exp_smi & !ack);
    if (cw) exp_cfg = merge_cfg(exp_cfg, cd, be);
    #1;
    check_all(tag);
    @(negedge clk);
    port_wr = 0; cfg_wr = 0; smi_ack = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset(1'b1, "R1");
    cyc(1, 8'h55, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 8'hF1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 4'b1000, 32'h0200_0000, 0, "R9");
    cyc(1, 8'h10, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(1, 8'hF0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 1, "R6");
    cyc(1, 8'hF1, 0, 0, 0, 0, "R2");
    cyc(1, 8'hF0, 0, 0, 0, 0, "R3");
    cyc(1, 8'hF2, 0, 0, 0, 0, "R4");
    cyc(1, 8'hEF, 0, 0, 0, 1, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R6");
    cyc(0, 0, 1, 4'b1000, 32'hFD00_0000, 0, "R9");
    cyc(1, 8'h33, 0, 0, 0, 0, "R9");
    cyc(0, 0, 1, 4'b0111, 32'hFFFF_FFFF, 0, "R9");
    cyc(0, 0, 1, 4'b1111, 32'h0000_0000, 0, "R9");
    cyc(1, 8'h44, 1, 4'b1000, 32'h0200_0000, 0, "R10");
    cyc(1, 8'h45, 0, 0, 0, 0, "R10");
    cyc(0, 0, 1, 4'b1000, 32'h0000_0000, 1, "R6");
    do_reset(1'b0, "R1");
    cyc(1, 8'h77, 0, 0, 0, 0, "R4");
    cyc(1, 8'hF1, 0, 0, 0, 1, "R2");
    for (int i = 0; i < 2000; i++) begin
      int unsigned sel = $urandom_range(0, 7);
      logic [7:0] d = (sel == 0) ? 8'hF1 : (sel == 1) ? 8'hF0 : 8'($urandom);
      bit pw = ($urandom_range(0, 3) != 0);
      bit cw = ($urandom_range(0, 4) == 0);
      logic [3:0] be = 4'($urandom);
      logic [31:0] cd = $urandom;
      bit ack = ($urandom_range(0, 3) == 0);
      cyc(pw, d, cw, be, cd, ack, "R6/R7/R9/R10");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule